// File: doc/BRIEF.md
# Multi-Source Heartbeat Rate Monitor

This block supervises several independent software tasks or hardware sources. Each source sends a one-cycle heartbeat strobe every time it completes an iteration. The block keeps a count of these strobes for each source. When the external check-period tick arrives, it tests every count against a window that belongs to that source. The window is exclusive at both ends.

If every source is inside its window and the system-health level is high, the block emits a one-cycle kick for a downstream watchdog counter and restarts all counts. Otherwise it withholds the kick, raises an error flag and records which sources were out of range. A source that has stalled blocks the kick, and so does one that is running too fast. The watchdog counter itself lives outside this block.

With the default parameters there are three sources. Their windows are (18,22), (8,12) and (6,10). These suit sources that beat every 50, 100 and 125 time units when the check period is 1000 units.

Top module: `hb_rate_monitor`

## Requirements
- R1: Each cycle in which a source's bit of `beat` is high (outside a check cycle) adds exactly one to that source's count.
- R2: A count saturates at 255 and never wraps. For example, 276 beats for source 0 must fail its window rather than look like 20.
- R3: Source i passes a check when its count C satisfies LO_i < C < HI_i. The default bounds are (18,22) for source 0, (8,12) for source 1 and (6,10) for source 2. A count equal to either bound fails.
- R4: `kick` goes high for exactly one cycle, in the cycle after a cycle with `period_tick` high, and only if every source passed and `sys_ok` was high in that tick cycle.
- R5: After a kick, every count restarts from zero, so a fresh nominal period passes again.
- R6: When a check does not pass, no kick is issued and `err` goes high. Both outputs take effect from the cycle after the tick and are held until the next check. The counts are kept, not cleared.
- R7: `fail_vec` bit i (bit 0 = source 0) is high exactly when source i failed its window at the last check. A check that fails only because `sys_ok` is low gives `err` = 1 with `fail_vec` = 0.
- R8: A heartbeat in the same cycle as `period_tick` is not part of that check. It is counted into the next period.
- R9: While `rst_n` is low at a clock edge, all counts clear and `kick`, `err` and `fail_vec` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beat | input | N_SRC | One heartbeat strobe per source |
| sys_ok | input | 1 | System health level, high means good |
| period_tick | input | 1 | One-cycle strobe marking the end of a check period |
| kick | output | 1 | One-cycle watchdog kick |
| err | output | 1 | Result of the last check was a failure |
| fail_vec | output | N_SRC | Per-source window violations at the last check |

## Verification
A heartbeat and the check tick can land in the same cycle. In that cycle the check uses the old count, while the restart (or retention) of the count must still absorb the new strobe. The bench provokes this in two ways. First, it runs a period that sits one beat below the upper bound and adds an extra strobe on the tick. Second, it runs a follow-up period that passes only if that strobe was carried into it. The kick and the flags after each tick are compared with a count model kept in the bench, and every window is swept across both of its bounds.

// File: rtl/hbmon_pkg.sv
// Package: shared count type for the heartbeat rate monitor.
// Assumes every source uses the same count width.
package hbmon_pkg;
    localparam int HB_CNT_W = 8;
    localparam logic [HB_CNT_W-1:0] HB_CNT_MAX = {HB_CNT_W{1'b1}};
    typedef logic [HB_CNT_W-1:0] hb_cnt_t;
endpackage

// File: rtl/hb_counter.sv
// Module: saturating heartbeat counter for one source.
// On restart the count takes the value of a beat in the same cycle, so
// that beat lands in the next period. Assumes beat is a one-cycle strobe.
module hb_counter
    import hbmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    beat,
    input  logic    restart,
    output hb_cnt_t cnt
);
    // Count beats, saturate at the maximum, restart after a kick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= beat ? hb_cnt_t'(1) : '0;
        else if (beat && cnt != HB_CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !restart && cnt != HB_CNT_MAX) |=> cnt == hb_cnt_t'($past(cnt) + 1'b1)); // R1
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == HB_CNT_MAX && !restart) |=> cnt == HB_CNT_MAX); // R2
endmodule

// File: rtl/hb_window.sv
// Module: exclusive window compare for one source's count.
// Assumes LO < HI; a count equal to either bound is out of range.
module hb_window
    import hbmon_pkg::*;
#(
    parameter hb_cnt_t LO = hb_cnt_t'(0),
    parameter hb_cnt_t HI = hb_cnt_t'(2)
) (
    input  hb_cnt_t cnt,
    output logic    in_win
);
    // Pass only when strictly between the two bounds.
    always_comb in_win = (cnt > LO) && (cnt < HI);
endmodule

// File: rtl/hb_verdict.sv
// Module: per-period verdict register.
// On a tick it registers the kick pulse, the error level and the
// per-source fail bits. It also tells the counters to restart when the
// check passes. Assumes period_tick is a one-cycle strobe.
module hb_verdict #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tick,
    input  logic             sys_ok,
    input  logic [N_SRC-1:0] in_win,
    output logic             restart,
    output logic             kick,
    output logic             err,
    output logic [N_SRC-1:0] fail_vec
);
    logic all_pass;

    // Combined pass condition for the current check.
    always_comb begin
        all_pass = sys_ok && (&in_win);
        restart  = period_tick && all_pass;
    end

    // Register the verdict; kick is a single-cycle pulse, flags hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick     <= 1'b0;
            err      <= 1'b0;
            fail_vec <= '0;
        end else if (period_tick) begin
            kick     <= all_pass;
            err      <= !all_pass;
            fail_vec <= ~in_win;
        end else begin
            kick     <= 1'b0;
        end
    end

    AST_KICK_NEEDS_TICK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> ($past(period_tick) && $past(sys_ok))); // R4
    AST_KICK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(kick && err)); // R6
    AST_FAIL_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (|fail_vec) |-> err); // R7
endmodule

// File: rtl/hb_rate_monitor.sv
// Module: top of the multi-source heartbeat rate monitor.
// It has one counter and one window per source, plus a shared verdict.
// Bounds are packed with source 0 in the least significant byte.
// Assumes synchronous inputs and one-cycle beat and tick strobes.
module hb_rate_monitor
    import hbmon_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter logic [N_SRC*HB_CNT_W-1:0] LO_BOUNDS = {8'd6,  8'd8,  8'd18},
    parameter logic [N_SRC*HB_CNT_W-1:0] HI_BOUNDS = {8'd10, 8'd12, 8'd22}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] beat,
    input  logic             sys_ok,
    input  logic             period_tick,
    output logic             kick,
    output logic             err,
    output logic [N_SRC-1:0] fail_vec
);
    logic             restart;
    logic [N_SRC-1:0] in_win;
    hb_cnt_t          cnt [N_SRC];

    // One counter and one window per source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam hb_cnt_t LO_I = LO_BOUNDS[i*HB_CNT_W +: HB_CNT_W];
        localparam hb_cnt_t HI_I = HI_BOUNDS[i*HB_CNT_W +: HB_CNT_W];

        hb_counter i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .beat    (beat[i]),
            .restart (restart),
            .cnt     (cnt[i])
        );

        hb_window #(.LO(LO_I), .HI(HI_I)) i_win (
            .cnt    (cnt[i]),
            .in_win (in_win[i])
        );

        AST_CLEARED_AFTER_KICK: assert property (@(posedge clk) disable iff (!rst_n)
            kick |-> (cnt[i] <= hb_cnt_t'(1))); // R5
    end

    hb_verdict #(.N_SRC(N_SRC)) i_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .sys_ok      (sys_ok),
        .in_win      (in_win),
        .restart     (restart),
        .kick        (kick),
        .err         (err),
        .fail_vec    (fail_vec)
    );
endmodule

// File: tb/test_hb_rate_monitor.sv
`timescale 1ns/1ps
module test_hb_rate_monitor;
    localparam int N = 3;
    localparam int LIMIT = 200000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] beat;
    logic         sys_ok;
    logic         period_tick;
    logic         kick;
    logic         err;
    logic [N-1:0] fail_vec;

    int vectors = 0;
    int miscompares = 0;
    int model [N];
    int lo [N] = '{18, 8, 6};
    int hi [N] = '{22, 12, 10};
    bit done = 0;

    always #2 clk = ~clk;

    hb_rate_monitor i_hb_rate_monitor (
        .clk(clk), .rst_n(rst_n), .beat(beat), .sys_ok(sys_ok),
        .period_tick(period_tick), .kick(kick), .err(err), .fail_vec(fail_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; beat = '0; period_tick = 1'b0; sys_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) model[i] = 0;
    endtask

    // Apply beats, tick with optional same-cycle beats, then check the verdict.
    task automatic run_period(input int n0, input int n1, input int n2,
                              input logic [N-1:0] tick_beat, input logic ok,
                              input string req);
        int n [N];
        int maxn;
        logic [N-1:0] exp_fail;
        logic exp_pass;
        n = '{n0, n1, n2};
        maxn = 0;
        for (int i = 0; i < N; i++) if (n[i] > maxn) maxn = n[i];
        for (int c = 0; c < maxn; c++) begin
            for (int i = 0; i < N; i++) beat[i] = (c < n[i]);
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            model[i] = model[i] + n[i];
            if (model[i] > 255) model[i] = 255;
            exp_fail[i] = !(model[i] > lo[i] && model[i] < hi[i]);
        end
        exp_pass = ok && (exp_fail == '0);
        period_tick = 1'b1; beat = tick_beat; sys_ok = ok;
        @(negedge clk);
        period_tick = 1'b0; beat = '0; sys_ok = 1'b1;
        chk({req, " kick"}, int'(kick), int'(exp_pass));
        chk({req, " err"}, int'(err), int'(!exp_pass));
        chk({req, " fail_vec R7"}, int'(fail_vec), int'(exp_fail));
        for (int i = 0; i < N; i++) begin
            if (exp_pass) model[i] = 0;
            model[i] = model[i] + int'(tick_beat[i]);
            if (model[i] > 255) model[i] = 255;
        end
        @(negedge clk);
        chk("R4 kick is one cycle", int'(kick), 0);
        chk("R6 err held", int'(err), int'(!exp_pass));
    endtask

    initial begin
        #(LIMIT * 4);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; beat = '0; period_tick = 1'b0; sys_ok = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R9 reset kick", int'(kick), 0);
        chk("R9 reset err", int'(err), 0);
        chk("R9 reset fail_vec", int'(fail_vec), 0);

        // R3 and R1: sweep each source across both bounds, others nominal.
        for (int s = 0; s < N; s++) begin
            for (int v = 0; v <= 25; v++) begin
                int n [N];
                n = '{20, 10, 8};
                n[s] = v;
                do_reset();
                run_period(n[0], n[1], n[2], '0, 1'b1, "R1 R3 sweep");
            end
        end

        // R2: 276 beats must saturate, not wrap to 20.
        do_reset();
        run_period(276, 10, 8, '0, 1'b1, "R2 saturate");
        run_period(0, 0, 0, '0, 1'b1, "R2 still saturated");

        // R6: failed period keeps counts; topping up then passes.
        do_reset();
        run_period(17, 10, 8, '0, 1'b1, "R6 low fail");
        run_period(3, 0, 0, '0, 1'b1, "R6 retained then pass");

        // R7: health low alone gives err without fail bits; counts kept.
        do_reset();
        run_period(20, 10, 8, '0, 1'b0, "R7 sys_ok low");
        run_period(0, 0, 0, '0, 1'b1, "R7 retained pass");
        run_period(30, 0, 8, '0, 1'b0, "R7 mixed fail");

        // R8: beats on the tick go to the next period.
        do_reset();
        run_period(21, 11, 9, 3'b111, 1'b1, "R8 tick beat excluded");
        run_period(18, 8, 6, '0, 1'b1, "R8 tick beat carried");

        // R5: counts restart after each kick.
        do_reset();
        for (int k = 0; k < 4; k++) run_period(20, 10, 8, '0, 1'b1, "R5 restart");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule